// File: doc/BRIEF.md
# Load/Store Memory Access Unit

This unit sits between a processor core and a byte-addressed data store that it holds itself. Each request carries an address, an access size (byte, halfword or word), a write flag and write data. The unit performs the access in one clock and returns exactly one response in the next cycle. The response holds the read data and a fault code.

Each access is first compared with the configured store size and then with the natural alignment of its size. A failing access is reported as a range fault or an alignment fault. If both conditions fail, only the range fault is reported. A faulting access leaves storage untouched, and a faulting read returns zero. Byte lanes are placed in big-endian or little-endian order according to a static configuration input. Reads narrower than a word are returned zero-extended in the low bits.

Top module: `lsu_mem`

## Requirements
- R1: A request whose unsigned address is greater than or equal to MEM_BYTES returns fault code 1 (range).
- R2: Size encoding is 0 = byte, 1 = halfword, 2 or 3 = word. A word access with address bits [1:0] not zero, or a halfword access with address bit 0 set, returns fault code 2 (alignment). Byte accesses never raise an alignment fault.
- R3: When an access is both out of range and misaligned, the fault code is 1 (range), never 2.
- R4: A faulting read returns read data zero, and a faulting write changes no stored byte.
- R5: With big_endian = 1, the most significant byte of the data sits at the lowest address of the access, and the following bytes sit at ascending addresses in descending significance.
- R6: With big_endian = 0, the least significant byte of the data sits at the lowest address, and the following bytes sit at ascending addresses in ascending significance.
- R7: Byte and halfword reads are zero-extended into bits [7:0] or [15:0]. Byte and halfword writes store only bits [7:0] or [15:0] of the write data.
- R8: Each request (req_valid = 1 at a clock edge) produces rsp_valid = 1 in the following cycle, and no request produces rsp_valid = 0. A successful access reports fault code 0, and a write response returns read data zero. Fault code 3 never appears.
- R9: Reset clears every stored byte to zero and deasserts rsp_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | Static lane order select: 1 big-endian, 0 little-endian |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| req_write | input | 1 | 1 for store, 0 for load |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | 32 | Zero-extended load data, zero on fault or store |
| rsp_fault | output | 2 | 0 none, 1 range, 2 alignment |

## Verification
The bench builds the unit with MEM_BYTES = 64, which keeps every stored byte within reach of a full readback. In each lane order, this store size allows a sweep over every address from zero to a few bytes past the end, for every access size, and a set of far addresses with low bits chosen to be misaligned. Between phases, a bytewise dump compares the whole store with an arithmetic model. This shows that faulting writes left no trace and that mixed-size and mixed-order accesses place bytes where the lane rules say. A reset in the middle of the run followed by a second dump exercises the clearing of storage.

// File: rtl/lsu_mem.sv
module lsu_mem #(
  parameter int unsigned MEM_BYTES = 2048,
  parameter int unsigned ADDR_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [1:0]        rsp_fault
);
  localparam int unsigned IDX_W = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;
  localparam int unsigned LANES = 4;
  localparam logic [1:0] F_NONE  = 2'd0;
  localparam logic [1:0] F_RANGE = 2'd1;
  localparam logic [1:0] F_ALIGN = 2'd2;

  logic [7:0]       store [MEM_BYTES];
  logic [IDX_W-1:0] base;
  logic [2:0]       nbytes;
  logic             out_of_range, misaligned;
  logic [1:0]       fault_nx;
  logic [1:0]       lane [LANES];
  logic [7:0]       wbyte [LANES];
  logic [31:0]      rd_nx;

  assign base         = req_addr[IDX_W-1:0];
  assign nbytes       = (req_size == 2'd0) ? 3'd1 : (req_size == 2'd1) ? 3'd2 : 3'd4;
  assign out_of_range = req_addr >= ADDR_W'(MEM_BYTES);
  assign misaligned   = (req_size == 2'd1 && req_addr[0]) || (req_size[1] && req_addr[1:0] != 2'b00);
  assign fault_nx     = out_of_range ? F_RANGE : misaligned ? F_ALIGN : F_NONE;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane[k]  = big_endian ? 2'(nbytes - 3'd1 - 3'(k)) : 2'(k);
    assign wbyte[k] = req_wdata[8*lane[k] +: 8];
  end

  always_comb begin
    rd_nx = '0;
    for (int k = 0; k < LANES; k++)
      if (3'(k) < nbytes)
        rd_nx[8*lane[k] +: 8] = store[base + IDX_W'(k)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) store[i] <= 8'h00;
    end else if (req_valid && req_write && fault_nx == F_NONE) begin
      for (int k = 0; k < LANES; k++)
        if (3'(k) < nbytes)
          store[base + IDX_W'(k)] <= wbyte[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_fault <= F_NONE;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid ? fault_nx : F_NONE;
      rsp_rdata <= (req_valid && !req_write && fault_nx == F_NONE) ? rd_nx : '0;
    end
  end
endmodule

module lsu_mem_props #(
  parameter int unsigned MEM_BYTES = 2048,
  parameter int unsigned ADDR_W    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              req_write,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic [1:0]        rsp_fault
);
  p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_addr >= ADDR_W'(MEM_BYTES) |=> rsp_fault == 2'd1);
  p_align_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_addr < ADDR_W'(MEM_BYTES) && req_size[1] && req_addr[1:0] != 2'b00 |=> rsp_fault == 2'd2);
  p_byte_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size == 2'd0 |=> rsp_fault != 2'd2);
  p_range_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_addr >= ADDR_W'(MEM_BYTES) && req_addr[0] && req_size != 2'd0 |=> rsp_fault != 2'd2);
  p_fault_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 2'd0 |-> rsp_rdata == 32'd0);
  p_zext_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && req_size == 2'd0 |=> rsp_rdata[31:8] == 24'd0);
  p_zext_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && req_size == 2'd1 |=> rsp_rdata[31:16] == 16'd0);
  p_one_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_write_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |=> rsp_rdata == 32'd0);
  p_code_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault != 2'd3);
endmodule

bind lsu_mem lsu_mem_props #(.MEM_BYTES(MEM_BYTES), .ADDR_W(ADDR_W)) u_props (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_size(req_size), .req_write(req_write), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault)
);

// File: tb/test_lsu_mem.sv
module test_lsu_mem;
  localparam int CLK_PERIOD = 10;
  localparam int MB = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic big_endian = 1'b1;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0] rsp_fault;

  int total = 0;
  int bad = 0;
  logic [7:0] mdl [MB];

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_mem #(.MEM_BYTES(MB), .ADDR_W(32)) i_lsu_mem (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .req_valid(req_valid),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_fault(rsp_fault)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%h size=%0d wr=%0d be=%0d act=%h exp=%h",
               r, req_addr, req_size, req_write, big_endian, act, exp);
    end
  endtask

  function automatic int nb(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [1:0] exp_fault(input logic [31:0] a, input logic [1:0] s);
    if (a >= 32'(MB)) return 2'd1;
    if (s == 2'd1 && a[0]) return 2'd2;
    if (s[1] && a[1:0] != 2'b00) return 2'd2;
    return 2'd0;
  endfunction

  task automatic access(input logic w, input logic [1:0] s, input logic [31:0] a, input logic [31:0] d);
    logic [1:0] ef;
    logic [31:0] er;
    int n;
    int ln;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_size = s; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    ef = exp_fault(a, s);
    n = nb(s);
    er = '0;
    if (ef == 2'd0) begin
      for (int k = 0; k < n; k++) begin
        ln = big_endian ? (n - 1 - k) : k;
        if (w) mdl[int'(a) + k] = d[8*ln +: 8];
        else   er[8*ln +: 8] = mdl[int'(a) + k];
      end
    end
    chk("R8 valid", 32'(rsp_valid), 32'd1);
    if (ef == 2'd1 && a[0] && s != 2'd0) chk("R3 range-before-align", 32'(rsp_fault), 32'(ef));
    else if (ef == 2'd1) chk("R1 range", 32'(rsp_fault), 32'(ef));
    else chk("R2 align", 32'(rsp_fault), 32'(ef));
    if (ef != 2'd0) chk("R4 zero on fault", rsp_rdata, 32'd0);
    else if (w) chk("R8 write rdata", rsp_rdata, 32'd0);
    else if (big_endian) chk("R5 R7 big-endian read", rsp_rdata, er);
    else chk("R6 R7 little-endian read", rsp_rdata, er);
  endtask

  task automatic dump(input string r);
    logic [31:0] got;
    for (int a = 0; a < MB; a++) begin
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_size = 2'd0; req_addr = 32'(a);
      @(negedge clk);
      req_valid = 1'b0;
      got = rsp_rdata;
      chk(r, got, {24'd0, mdl[a]});
    end
  endtask

  task automatic sweep(input logic w);
    logic [31:0] far [4];
    far[0] = 32'(MB) + 32'd1; far[1] = 32'hFFFF_FFFF; far[2] = 32'h8000_0002; far[3] = 32'(MB);
    for (int s = 0; s < 4; s++) begin
      for (int a = 0; a < MB + 4; a++)
        access(w, 2'(s), 32'(a), 32'hA55A_0F3C ^ (32'(a) * 32'h0103_0507) ^ 32'(s << 28));
      for (int f = 0; f < 4; f++)
        access(w, 2'(s), far[f], 32'hDEAD_BEEF);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < MB; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 no response after reset", 32'(rsp_valid), 32'd0);
    dump("R9 cleared store");
    big_endian = 1'b1;
    sweep(1'b1);
    dump("R4 R5 store after big-endian writes");
    sweep(1'b0);
    big_endian = 1'b0;
    sweep(1'b0);
    sweep(1'b1);
    dump("R4 R6 store after little-endian writes");
    access(1'b1, 2'd0, 32'd5, 32'hFFFF_FF77);
    access(1'b1, 2'd1, 32'd6, 32'hFFFF_1234);
    dump("R7 narrow write uses low bits");
    big_endian = 1'b1;
    access(1'b0, 2'd2, 32'd4, 32'd0);
    sweep(1'b0);
    @(negedge clk);
    chk("R8 idle cycle no response", 32'(rsp_valid), 32'd0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < MB; i++) mdl[i] = 8'h00;
    chk("R9 valid low after reset", 32'(rsp_valid), 32'd0);
    dump("R9 store cleared by reset");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule